// File: doc/BRIEF.md
# Peripheral Interrupt Forwarding Controller

This block sits between a set of peripheral interrupt lines and the shared peripheral inputs of a top-level interrupt controller. Every implemented input has three pieces of per-line state: a mask bit, a polarity bit and, in the latched build, a pending flag. Software reaches this state through a small word-addressed register port. Only the lower 16 data bits of that port carry information. Each input drives one line of the parent vector. Input i appears on parent line i plus a fixed base offset.

A build parameter picks one of two variants. The pass-through variant senses by level: the synchronised input, adjusted for polarity and then masked, drives its parent line directly. The latched variant senses by edge: a pending flag sets on the selected edge, holds until software writes a one to the matching clear bit, and drives its parent line when the input is unmasked.

The register decode is the block's only state-like structure. Two address bits choose one of four regions: MASK, POL, CLR and NONE. The two bits below them choose a 16-bit bank. A write request in MASK or POL replaces the bits of the chosen bank. A write request in CLR pulses the clear lines for one cycle. A write request in NONE does nothing. A read request in MASK, POL or CLR returns the mask, polarity or pending word of the chosen bank. A read request in NONE returns zero.

Top module: `pfc_fwd`

## Requirements
- R1: After reset every implemented mask bit is 1, every polarity bit is 0, every pending flag is 0 and the whole parent vector is 0.
- R2: The word address carries the region in bits [3:2] (0 mask, 1 polarity, 2 clear/pending) and the bank in bits [1:0]. Input n sits at bit n%16 of bank n/16, and a write to a mask or polarity bank replaces all 16 bits of that bank.
- R3: Read data appears on `bus_rdata` one cycle after the read request. Bits 31:16 read as zero, and so do the bits of inputs that are not implemented; writes to any of these bits have no effect.
- R4: A mask bit of 1 holds the input's parent line low; a mask bit of 0 lets the input through.
- R5: In the pass-through variant, a polarity bit of 0 makes a high input active and a polarity bit of 1 makes a low input active. The parent line follows the input after the two-flop synchroniser, so it changes at the second clock edge after the input changes.
- R6: In the latched variant, a polarity bit of 0 sets the pending flag on a falling edge and a polarity bit of 1 sets it on a rising edge. The opposite edge never sets the flag, and the flag stays set after the input returns.
- R7: Writing 1 to a bit of the clear region clears that pending flag; writing 0 leaves it unchanged.
- R8: If a clear request and a new edge reach the same flag in the same cycle, the flag ends up set.
- R9: Output line i drives parent bit i + PARENT_BASE; every other parent bit stays 0.
- R10: In the latched variant, an edge on a masked input still sets the pending flag. The parent line shows the flag only when the input is unmasked.
- R11: Word addresses 12 to 15 (region 3) read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Peripheral interrupt lines, asynchronous |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 for a write request, 0 for a read request |
| bus_addr | input | 4 | Word address: region in bits [3:2], bank in bits [1:0] |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read request |
| parent_irq | output | PARENT_W | Interrupt lines to the parent controller |

## Verification
The case hardest to reach from the ports is the collision of a clear write with a new edge on the same flag. The clear request has to arrive at exactly the clock edge where the synchronised edge is first seen. The stimulus changes the input on a falling clock edge and waits one full cycle. It then issues the clear, so the write is captured at the third rising edge, the same edge at which the flag sets. The same sequence is also run with the clear captured one cycle earlier and one cycle later, which pins down that edge exactly. The rest of the bench sweeps every implemented input through both polarities, masking and clearing, on a pass-through instance and on a latched instance.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned BANK_W = 16;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned SPAN   = 4 * BANK_W;   // four banks per region

    typedef enum logic [1:0] {
        RGN_MASK = 2'd0,
        RGN_POL  = 2'd1,
        RGN_CLR  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
#(
    parameter int unsigned NUM_IN = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [NUM_IN-1:0] stat_i,
    output logic [NUM_IN-1:0] mask_o,
    output logic [NUM_IN-1:0] pol_o,
    output logic [NUM_IN-1:0] clr_o,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int unsigned LOW = (NUM_IN < BANK_W) ? NUM_IN : BANK_W;

    region_e            rgn;
    logic [1:0]         bank;
    logic               wr;
    logic [NUM_IN-1:0]  lane_sel;
    logic [NUM_IN-1:0]  lane_dat;
    logic [BANK_W-1:0]  rd_word;
    logic [NUM_IN-1:0]  mask_q;
    logic [NUM_IN-1:0]  pol_q;
    wire                unused_wdata_hi = ^bus_wdata[BUS_W-1:BANK_W];

    assign rgn  = region_e'(bus_addr[3:2]);
    assign bank = bus_addr[1:0];
    assign wr   = bus_valid && bus_write;

    // Bank lanes, truncated to the implemented inputs
    assign lane_sel = NUM_IN'(SPAN'({BANK_W{1'b1}}) << (BANK_W * bank));
    assign lane_dat = NUM_IN'(SPAN'(bus_wdata[BANK_W-1:0]) << (BANK_W * bank));

    // Region decode: writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '0;
        end else if (wr) begin
            unique case (rgn)
                RGN_MASK: mask_q <= (mask_q & ~lane_sel) | lane_dat;
                RGN_POL:  pol_q  <= (pol_q & ~lane_sel) | lane_dat;
                default:  ;
            endcase
        end
    end

    assign clr_o  = (wr && rgn == RGN_CLR) ? lane_dat : '0;
    assign mask_o = mask_q;
    assign pol_o  = pol_q;

    // Region decode: reads
    always_comb begin
        unique case (rgn)
            RGN_MASK: rd_word = BANK_W'(SPAN'(mask_q) >> (BANK_W * bank));
            RGN_POL:  rd_word = BANK_W'(SPAN'(pol_q)  >> (BANK_W * bank));
            RGN_CLR:  rd_word = BANK_W'(SPAN'(stat_i) >> (BANK_W * bank));
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_valid && !bus_write)
            bus_rdata <= {{(BUS_W - BANK_W){1'b0}}, rd_word};
    end

    // R2: a full-bank write to mask bank 0 is visible the next cycle
    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 4'd0)
        |=> (mask_o[LOW-1:0] == $past(bus_wdata[LOW-1:0])));

    // R3: upper half of read data is never driven
    p_rdata_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:BANK_W] == '0);

    // R11: reads in the empty region return zero
    p_none_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[3:2] == 2'b11) |=> (bus_rdata == '0));
endmodule

// File: rtl/pfc_latch.sv
module pfc_latch #(
    parameter int unsigned NUM_IN = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] lvl_i,
    input  logic [NUM_IN-1:0] pol_i,
    input  logic [NUM_IN-1:0] clr_i,
    output logic [NUM_IN-1:0] stat_o
);
    logic [NUM_IN-1:0] prev_q;
    logic [NUM_IN-1:0] hit;

    // pol 1: rising edge, pol 0: falling edge
    assign hit = (pol_i & lvl_i & ~prev_q) | (~pol_i & ~lvl_i & prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_o <= '0;
        end else begin
            prev_q <= lvl_i;
            stat_o <= (stat_o & ~clr_i) | hit;
        end
    end

    // R6: a pending flag without a clear request stays set
    p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_o) & ~$past(clr_i) & ~stat_o) == '0));

    // R7: a clear without a concurrent edge empties the flag
    p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o & $past(clr_i & ~hit)) == '0));

    // R8: an edge always leaves the flag set, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hit) & ~stat_o) == '0));
endmodule

// File: rtl/pfc_fwd.sv
module pfc_fwd
    import pfc_pkg::*;
#(
    parameter int unsigned NUM_IN      = 20,
    parameter bit          LATCHED     = 1'b1,
    parameter int unsigned PARENT_W    = 32,
    parameter int unsigned PARENT_BASE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   irq_in,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [PARENT_W-1:0] parent_irq
);
    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] mask;
    logic [NUM_IN-1:0] pol;
    logic [NUM_IN-1:0] clr;
    logic [NUM_IN-1:0] stat;
    logic [NUM_IN-1:0] fire;

    pfc_sync #(.W(NUM_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (lvl)
    );

    pfc_regs #(.NUM_IN(NUM_IN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_i    (stat),
        .mask_o    (mask),
        .pol_o     (pol),
        .clr_o     (clr),
        .bus_rdata (bus_rdata)
    );

    generate
        if (LATCHED) begin : g_latched
            pfc_latch #(.NUM_IN(NUM_IN)) u_latch (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (lvl),
                .pol_i  (pol),
                .clr_i  (clr),
                .stat_o (stat)
            );
            assign fire = stat & ~mask;
        end else begin : g_pass
            wire unused_clr = ^clr;
            assign stat = '0;
            assign fire = (lvl ^ pol) & ~mask;
        end
    endgenerate

    assign parent_irq = PARENT_W'(fire) << PARENT_BASE;
endmodule

// File: tb/tb_pfc_fwd.sv
module tb_pfc_fwd;
    localparam int CLK_PERIOD = 10;
    localparam int NI   = 20;
    localparam int PW   = 32;
    localparam int BASE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_lat = '0;
    logic [NI-1:0] irq_pt = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rd_lat, rd_pt;
    logic [PW-1:0] par_lat, par_pt;
    int            checks = 0;
    int            errors = 0;
    logic [31:0]   v_lat, v_pt;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfc_fwd #(.NUM_IN(NI), .LATCHED(1'b1), .PARENT_W(PW), .PARENT_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_lat), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_lat), .parent_irq(par_lat));

    pfc_fwd #(.NUM_IN(NI), .LATCHED(1'b0), .PARENT_W(PW), .PARENT_BASE(BASE)) dut_pt (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_pt), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_pt), .parent_irq(par_pt));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v_lat = rd_lat; v_pt = rd_pt;
    endtask

    function automatic logic [31:0] bitw(input int n);
        return 32'(1) << (n % 16);
    endfunction

    function automatic logic [3:0] wa(input int region, input int n);
        return 4'(region * 4 + n / 16);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 parent lat", par_lat, '0);
        check("R1 parent pt", par_pt, '0);
        rd(4'd0); check("R1 mask bank0", v_lat, 32'h0000_FFFF);
        rd(4'd1); check("R1 mask bank1", v_pt, 32'h0000_000F);
        rd(4'd4); check("R1 pol bank0", v_pt, 32'h0);
        rd(4'd8); check("R1 pending bank0", v_lat, 32'h0);
        rd(4'd9); check("R1 pending bank1", v_lat, 32'h0);

        // R3: unimplemented bits and upper half
        wr(4'd1, 32'hFFFF_0000); rd(4'd1); check("R3 hi ignored", v_lat, 32'h0);
        wr(4'd5, 32'hABCD_FFFF); rd(4'd5); check("R3 pol bank1 trunc", v_pt, 32'h0000_000F);
        wr(4'd6, 32'h0000_FFFF); rd(4'd6); check("R3 unbuilt bank", v_pt, 32'h0);
        wr(4'd5, 32'h0);

        // R11: empty region
        wr(4'd12, 32'h0000_0000); rd(4'd0); check("R11 mask untouched", v_lat, 32'h0000_FFFF);
        for (int a = 12; a < 16; a++) begin
            rd(4'(a)); check("R11 read zero", v_pt, 32'h0);
        end

        // R4, R5, R9: pass-through sweep
        wr(4'd0, 32'h0); wr(4'd1, 32'h0);
        for (int n = 0; n < NI; n++) begin
            irq_pt = NI'(1) << n;
            @(negedge clk); @(negedge clk);
            check("R5 high active", par_pt, 32'(1) << (n + BASE));
            wr(wa(1, n), bitw(n));
            rd(wa(1, n)); check("R2 pol readback", v_pt, bitw(n));
            check("R5 inverted high idle", par_pt, 32'h0);
            irq_pt = '0;
            @(negedge clk); @(negedge clk);
            check("R9 low active", par_pt, 32'(1) << (n + BASE));
            wr(wa(0, n), bitw(n));
            check("R4 masked", par_pt, 32'h0);
            wr(wa(0, n), 32'h0);
            check("R4 unmasked", par_pt, 32'(1) << (n + BASE));
            wr(wa(1, n), 32'h0);
            check("R5 restored idle", par_pt, 32'h0);
        end

        // R6, R7, R9: latched sweep
        for (int n = 0; n < NI; n++) begin
            irq_lat = NI'(1) << n;
            repeat (4) @(negedge clk);
            rd(wa(2, n)); check("R6 rising ignored pol0", v_lat, 32'h0);
            irq_lat = '0;
            repeat (4) @(negedge clk);
            rd(wa(2, n)); check("R6 falling sets", v_lat, bitw(n));
            check("R9 latched parent", par_lat, 32'(1) << (n + BASE));
            wr(wa(2, n), 32'h0);
            rd(wa(2, n)); check("R7 zero no effect", v_lat, bitw(n));
            wr(wa(2, n), bitw(n));
            rd(wa(2, n)); check("R7 clear", v_lat, 32'h0);
            check("R7 parent drops", par_lat, 32'h0);
            wr(wa(1, n), bitw(n));
            irq_lat = NI'(1) << n;
            repeat (4) @(negedge clk);
            rd(wa(2, n)); check("R6 rising sets pol1", v_lat, bitw(n));
            wr(wa(2, n), bitw(n));
            irq_lat = '0;
            repeat (4) @(negedge clk);
            rd(wa(2, n)); check("R6 falling ignored pol1", v_lat, 32'h0);
            wr(wa(1, n), 32'h0);
        end

        // R10: masked edge still pends
        wr(4'd0, 32'h0000_0020);
        irq_lat = NI'(1) << 5;
        repeat (4) @(negedge clk);
        irq_lat = '0;
        repeat (4) @(negedge clk);
        check("R10 masked parent low", par_lat, 32'h0);
        rd(4'd8); check("R10 pending while masked", v_lat, 32'h0000_0020);
        wr(4'd0, 32'h0);
        check("R10 unmask shows", par_lat, 32'(1) << (5 + BASE));
        wr(4'd8, 32'h0000_0020);

        // R8: collision of clear and edge on input 17 (pol 1, rising)
        wr(4'd5, 32'h0000_0002);
        irq_lat = NI'(1) << 17;
        repeat (4) @(negedge clk);
        irq_lat = '0;
        repeat (4) @(negedge clk);
        rd(4'd9); check("R8 preset", v_lat, 32'h2);
        irq_lat = NI'(1) << 17;          // edge seen at third rising edge
        @(negedge clk);
        wr(4'd9, 32'h2);                 // captured at that same edge
        rd(4'd9); check("R8 set wins", v_lat, 32'h2);
        irq_lat = '0;
        repeat (4) @(negedge clk);
        wr(4'd9, 32'h2);
        irq_lat = NI'(1) << 17;          // clear one cycle early
        wr(4'd9, 32'h2);
        repeat (3) @(negedge clk);
        rd(4'd9); check("R8 early clear then set", v_lat, 32'h2);
        irq_lat = '0;
        repeat (4) @(negedge clk);
        wr(4'd9, 32'h2);
        irq_lat = NI'(1) << 17;          // clear one cycle late
        @(negedge clk); @(negedge clk);
        wr(4'd9, 32'h2);
        rd(4'd9); check("R8 late clear wins", v_lat, 32'h0);
        check("R9 parent idle", par_lat, 32'h0);

        finish_run();
    end
endmodule